// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block is a real-time clock core. It holds eight 8-bit registers in binary-coded decimal: hundredths of a second, seconds, minutes, hours, day of week, date, month and year. A tick enable at 100 Hz moves the count forward. The parameter `PRESCALE` lets a faster tick be divided down inside the block. The hours register can count in either 12-hour or 24-hour form. The day-of-week register also carries two control flags. One flag halts the count. The other decides whether an external reset pin may abort a transfer in progress.

A serial access sequencer next to this core uses two parallel operations. A one-cycle load strobe writes all eight registers at once. A one-cycle snapshot strobe copies all eight registers into a holding output, so the sequencer can shift them out while the clock keeps running. Month lengths are derived from the month and the two-digit year, and leap years are included.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read, from register 0 to register 7: 00, 00, 00, 00, 31, 01, 01, 00 (hex). The day register therefore starts with the oscillator-stop bit (bit 5) and the reset-enable bit (bit 4) both at 1, and day of week 1.
- R2: The registers are packed into the 64-bit load and snapshot buses with register k in bits [8k+7:8k]. Register order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Each counting step adds one hundredth. Hundredths wrap from 99 to 00, and seconds and minutes wrap from 59 to 00. Each wrap carries into the next register. All digits stay in BCD.
- R3: When hours bit 7 is 0 (24-hour mode), the hours count 00 to 23 in bits 5:0. The step from 23:59:59.99 gives 00:00:00.00 and advances the calendar by one day.
- R4: When hours bit 7 is 1 (12-hour mode), bits 4:0 hold 01 to 12 and bit 5 is the PM flag (1 = PM). The count runs 12, 01, …, 11. The step from 11 to 12 toggles PM. The calendar advances only when the step is from 11 PM to 12 AM.
- R5: Day of week, in bits 2:0 of register 4, counts 1 to 7 and wraps to 1. Bits 5 and 4 are kept unchanged.
- R6: Dates wrap after the last day of the month. April, June, September and November have 30 days. February has 29 days when the two BCD year digits form a multiple of 4 (00 included), and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: While day register bit 5 is 1, ticks change no register.
- R8: `abort_o` is 1 exactly when `ext_rst_n_i` is low and day register bit 4 is 0. Neither case changes any clock register.
- R9: Unused bits always read 0. Written values go through these masks, register 0 to 7: FF, 7F, 7F, BF, 37, 3F, 1F, FF.
- R10: A load in the same cycle as a tick stores the loaded values unchanged. The load wins.
- R11: A snapshot strobe presents all eight registers on `snap_data_o` from the next cycle, and they are held there until the next strobe.
- R12: With `PRESCALE` = N, the hundredths register advances once per N ticks accepted while the oscillator runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable, one pulse per tick |
| load_i | input | 1 | Bulk write strobe |
| load_data_i | input | 64 | Values for all eight registers |
| snap_i | input | 1 | Snapshot strobe |
| snap_data_o | output | 64 | Captured copy of all eight registers |
| ext_rst_n_i | input | 1 | External transfer reset, active low |
| abort_o | output | 1 | Abort request to the serial sequencer |

## Verification
The bench builds two copies of the core. The first uses `PRESCALE` = 1, so every tick is one hundredth and any rollover can be reached one tick after loading a time just before it. The second uses `PRESCALE` = 4; it shows that the divided path holds the count for three accepted ticks and steps on the fourth. Preloaded edge times exercise every month length and the leap-year rule. They also cover both hour modes and the year and week wraps.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int RTC_NREG = 8;
   localparam int RTC_W    = 8;
   localparam int RTC_BUSW = RTC_NREG * RTC_W;

   localparam int IDX_HUND  = 0;
   localparam int IDX_SEC   = 1;
   localparam int IDX_MIN   = 2;
   localparam int IDX_HOUR  = 3;
   localparam int IDX_DAY   = 4;
   localparam int IDX_DATE  = 5;
   localparam int IDX_MONTH = 6;
   localparam int IDX_YEAR  = 7;

   localparam int HOUR_MODE_BIT = 7;
   localparam int HOUR_PM_BIT   = 5;
   localparam int DAY_OSC_BIT   = 5;
   localparam int DAY_RSTEN_BIT = 4;

   typedef logic [RTC_W-1:0] bcd_byte_t;

   function automatic bcd_byte_t rtc_mask(input int k);
      case (k)
         IDX_HUND:  return 8'hFF;
         IDX_SEC:   return 8'h7F;
         IDX_MIN:   return 8'h7F;
         IDX_HOUR:  return 8'hBF;
         IDX_DAY:   return 8'h37;
         IDX_DATE:  return 8'h3F;
         IDX_MONTH: return 8'h1F;
         default:   return 8'hFF;
      endcase
   endfunction

   function automatic bcd_byte_t rtc_reset_val(input int k);
      case (k)
         IDX_DAY:   return 8'h31;
         IDX_DATE:  return 8'h01;
         IDX_MONTH: return 8'h01;
         default:   return 8'h00;
      endcase
   endfunction

   function automatic logic [RTC_BUSW-1:0] rtc_mask_flat();
      logic [RTC_BUSW-1:0] m;
      for (int k = 0; k < RTC_NREG; k++) m[k*RTC_W +: RTC_W] = rtc_mask(k);
      return m;
   endfunction

   function automatic bcd_byte_t bcd_inc(input bcd_byte_t v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic bcd_byte_t bcd_wrap(input bcd_byte_t v, input bcd_byte_t last,
                                          input bcd_byte_t first);
      return (v == last) ? first : bcd_inc(v);
   endfunction

   function automatic logic bcd_year_leap(input bcd_byte_t y);
      case ({y[4], y[3:0]})
         5'h00, 5'h04, 5'h08, 5'h12, 5'h16: return 1'b1;
         default:                           return 1'b0;
      endcase
   endfunction

   function automatic bcd_byte_t bcd_month_last(input bcd_byte_t mon, input bcd_byte_t yr);
      case (mon)
         8'h02:                      return bcd_year_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler #(
   parameter int PRESCALE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic step_o
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("rtc_tick_prescaler: PRESCALE must be at least 1");
      end else if (PRESCALE == 1) begin : g_direct
         assign step_o = tick_i;
      end else begin : g_divided
         localparam int CW = $clog2(PRESCALE);
         localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign step_o = tick_i && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/rtc_subsec_chain.sv
module rtc_subsec_chain
   import rtc_pkg::*;
(
   input  logic      step_i,
   input  bcd_byte_t hund_i,
   input  bcd_byte_t sec_i,
   input  bcd_byte_t min_i,
   output bcd_byte_t hund_o,
   output bcd_byte_t sec_o,
   output bcd_byte_t min_o,
   output logic      carry_o
);
   logic c_hund, c_sec, c_min;

   always_comb begin
      c_hund = step_i && (hund_i == 8'h99);
      c_sec  = c_hund && (sec_i == 8'h59);
      c_min  = c_sec && (min_i == 8'h59);
      hund_o = step_i ? bcd_wrap(hund_i, 8'h99, 8'h00) : hund_i;
      sec_o  = c_hund ? bcd_wrap(sec_i, 8'h59, 8'h00) : sec_i;
      min_o  = c_sec ? bcd_wrap(min_i, 8'h59, 8'h00) : min_i;
      carry_o = c_min;
   end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
   import rtc_pkg::*;
(
   input  logic      step_i,
   input  bcd_byte_t hour_i,
   output bcd_byte_t hour_o,
   output logic      day_carry_o
);
   bcd_byte_t h24, h12;
   logic      pm;

   always_comb begin
      hour_o      = hour_i;
      day_carry_o = 1'b0;
      h24 = {2'b00, hour_i[5:0]};
      h12 = {3'b000, hour_i[4:0]};
      pm  = hour_i[HOUR_PM_BIT];
      if (step_i) begin
         if (hour_i[HOUR_MODE_BIT]) begin
            if (h12 == 8'h11) begin
               h12         = 8'h12;
               day_carry_o = pm;
               pm          = ~pm;
            end else if (h12 == 8'h12) begin
               h12 = 8'h01;
            end else begin
               h12 = bcd_inc(h12);
            end
            hour_o = {1'b1, 1'b0, pm, h12[4:0]};
         end else begin
            day_carry_o = (h24 == 8'h23);
            h24         = bcd_wrap(h24, 8'h23, 8'h00);
            hour_o      = {1'b0, 1'b0, h24[5:0]};
         end
      end
   end
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
   import rtc_pkg::*;
(
   input  logic      step_i,
   input  bcd_byte_t day_i,
   input  bcd_byte_t date_i,
   input  bcd_byte_t month_i,
   input  bcd_byte_t year_i,
   output bcd_byte_t day_o,
   output bcd_byte_t date_o,
   output bcd_byte_t month_o,
   output bcd_byte_t year_o
);
   bcd_byte_t last_date;
   logic      c_date, c_month;

   always_comb begin
      last_date = bcd_month_last(month_i, year_i);
      c_date    = step_i && (date_i == last_date);
      c_month   = c_date && (month_i == 8'h12);
      day_o     = day_i;
      if (step_i)
         day_o[2:0] = (day_i[2:0] == 3'd7) ? 3'd1 : day_i[2:0] + 3'd1;
      date_o  = step_i ? bcd_wrap(date_i, last_date, 8'h01) : date_i;
      month_o = c_date ? bcd_wrap(month_i, 8'h12, 8'h01) : month_i;
      year_o  = c_month ? bcd_wrap(year_i, 8'h99, 8'h00) : year_i;
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                load_i,
   input  logic [RTC_BUSW-1:0] load_data_i,
   input  logic                snap_i,
   output logic [RTC_BUSW-1:0] snap_data_o,
   input  logic                ext_rst_n_i,
   output logic                abort_o
);
   localparam logic [RTC_BUSW-1:0] USED = rtc_mask_flat();

   bcd_byte_t           regs_q [RTC_NREG];
   bcd_byte_t           regs_d [RTC_NREG];
   logic [RTC_BUSW-1:0] state_q;
   logic                osc_run, tick_ok, step, hour_step, day_step;

   genvar gi;
   generate
      for (gi = 0; gi < RTC_NREG; gi++) begin : g_flat
         assign state_q[gi*RTC_W +: RTC_W] = regs_q[gi];
      end
   endgenerate

   assign osc_run = ~regs_q[IDX_DAY][DAY_OSC_BIT];
   assign tick_ok = tick_i && osc_run && !load_i;

   rtc_tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_ok), .step_o(step)
   );

   rtc_subsec_chain u_sub (
      .step_i(step),
      .hund_i(regs_q[IDX_HUND]), .sec_i(regs_q[IDX_SEC]), .min_i(regs_q[IDX_MIN]),
      .hund_o(regs_d[IDX_HUND]), .sec_o(regs_d[IDX_SEC]), .min_o(regs_d[IDX_MIN]),
      .carry_o(hour_step)
   );

   rtc_hour_step u_hour (
      .step_i(hour_step), .hour_i(regs_q[IDX_HOUR]),
      .hour_o(regs_d[IDX_HOUR]), .day_carry_o(day_step)
   );

   rtc_calendar_step u_cal (
      .step_i(day_step),
      .day_i(regs_q[IDX_DAY]), .date_i(regs_q[IDX_DATE]),
      .month_i(regs_q[IDX_MONTH]), .year_i(regs_q[IDX_YEAR]),
      .day_o(regs_d[IDX_DAY]), .date_o(regs_d[IDX_DATE]),
      .month_o(regs_d[IDX_MONTH]), .year_o(regs_d[IDX_YEAR])
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < RTC_NREG; k++) regs_q[k] <= rtc_reset_val(k);
      end else if (load_i) begin
         for (int k = 0; k < RTC_NREG; k++)
            regs_q[k] <= load_data_i[k*RTC_W +: RTC_W] & USED[k*RTC_W +: RTC_W];
      end else if (step) begin
         for (int k = 0; k < RTC_NREG; k++) regs_q[k] <= regs_d[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      snap_data_o <= '0;
      else if (snap_i) snap_data_o <= state_q;
   end

   assign abort_o = !ext_rst_n_i && !regs_q[IDX_DAY][DAY_RSTEN_BIT];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
   import rtc_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                load_i,
   input logic [RTC_BUSW-1:0] load_data_i,
   input logic [RTC_BUSW-1:0] state_q,
   input logic                ext_rst_n_i,
   input logic                abort_o
);
   localparam logic [RTC_BUSW-1:0] USED = rtc_mask_flat();
   localparam int OSC_POS   = IDX_DAY * RTC_W + DAY_OSC_BIT;
   localparam int RSTEN_POS = IDX_DAY * RTC_W + DAY_RSTEN_BIT;

   // R9
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q & ~USED) == '0);

   // R7
   osc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q[OSC_POS] && !load_i) |=> $stable(state_q));

   // R10
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (state_q == ($past(load_data_i) & USED)));

   // R8
   abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (!ext_rst_n_i && !state_q[RSTEN_POS]));

   // R8
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst_n_i |-> !abort_o);
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
   .state_q(state_q), .ext_rst_n_i(ext_rst_n_i), .abort_o(abort_o)
);

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0, tick_d = 1'b0;
   logic        load_i = 1'b0;
   logic [63:0] load_data_i = '0;
   logic        snap_i = 1'b0;
   logic        ext_rst_n_i = 1'b1;
   logic [63:0] snap_a, snap_b;
   logic        abort_a, abort_b;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   bcd_rtc_core #(.PRESCALE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
      .load_data_i(load_data_i), .snap_i(snap_i), .snap_data_o(snap_a),
      .ext_rst_n_i(ext_rst_n_i), .abort_o(abort_a)
   );

   bcd_rtc_core #(.PRESCALE(4)) dut_div_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_d), .load_i(load_i),
      .load_data_i(load_data_i), .snap_i(snap_i), .snap_data_o(snap_b),
      .ext_rst_n_i(ext_rst_n_i), .abort_o(abort_b)
   );

   function automatic logic [63:0] pack(input logic [7:0] hu, s, mi, hr, dy, dt, mo, yr);
      return {yr, mo, dt, dy, hr, mi, s, hu};
   endfunction

   function automatic logic [63:0] edge_t(input logic [7:0] hr, dy, dt, mo, yr);
      return pack(8'h99, 8'h59, 8'h59, hr, dy, dt, mo, yr);
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_load(input logic [63:0] v);
      @(negedge clk) begin load_i = 1'b1; load_data_i = v; end
      @(negedge clk) load_i = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      @(negedge clk) tick_i = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk) tick_i = 1'b0;
   endtask

   task automatic do_snap();
      @(negedge clk) snap_i = 1'b1;
      @(negedge clk) snap_i = 1'b0;
   endtask

   task automatic roll_case(input string tag, input logic [63:0] start, input logic [63:0] exp);
      do_load(start);
      do_ticks(1);
      do_snap();
      check(tag, snap_a, exp);
   endtask

   task automatic t_reset();
      do_snap();
      check("R1 reset values", snap_a, pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00));
      ext_rst_n_i = 1'b0;
      #1 check("R1 reset-enable set blocks abort", {63'd0, abort_a}, 64'd0);
      ext_rst_n_i = 1'b1;
   endtask

   task automatic t_mask();
      do_load({64{1'b1}});
      do_snap();
      check("R9 unused bits read zero", snap_a,
            pack(8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h37, 8'h3F, 8'h1F, 8'hFF));
   endtask

   task automatic t_count();
      do_load(pack(8'h98, 8'h58, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
      do_ticks(2);
      do_snap();
      check("R2 hundredths wrap to seconds", snap_a,
            pack(8'h00, 8'h59, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
      do_ticks(100);
      do_snap();
      check("R2 seconds wrap to minutes", snap_a,
            pack(8'h00, 8'h00, 8'h01, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
      do_ticks(7);
      do_snap();
      check("R2 BCD digit carry", snap_a,
            pack(8'h07, 8'h00, 8'h01, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
   endtask

   task automatic t_24h();
      roll_case("R3 R5 R6 end of year", edge_t(8'h23, 8'h17, 8'h31, 8'h12, 8'h99),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
      roll_case("R3 19 to 20", edge_t(8'h19, 8'h12, 8'h05, 8'h03, 8'h10),
                pack(8'h00, 8'h00, 8'h00, 8'h20, 8'h12, 8'h05, 8'h03, 8'h10));
   endtask

   task automatic t_12h();
      roll_case("R4 11 AM to 12 PM", edge_t(8'h91, 8'h13, 8'h15, 8'h05, 8'h21),
                pack(8'h00, 8'h00, 8'h00, 8'hB2, 8'h13, 8'h15, 8'h05, 8'h21));
      roll_case("R4 11 PM to 12 AM next day", edge_t(8'hB1, 8'h13, 8'h15, 8'h05, 8'h21),
                pack(8'h00, 8'h00, 8'h00, 8'h92, 8'h14, 8'h16, 8'h05, 8'h21));
      roll_case("R4 12 to 01", edge_t(8'h92, 8'h13, 8'h15, 8'h05, 8'h21),
                pack(8'h00, 8'h00, 8'h00, 8'h81, 8'h13, 8'h15, 8'h05, 8'h21));
      roll_case("R4 09 to 10 PM", edge_t(8'hA9, 8'h13, 8'h15, 8'h05, 8'h21),
                pack(8'h00, 8'h00, 8'h00, 8'hB0, 8'h13, 8'h15, 8'h05, 8'h21));
   endtask

   task automatic t_months();
      roll_case("R6 April 30 to May 1", edge_t(8'h23, 8'h11, 8'h30, 8'h04, 8'h22),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h05, 8'h22));
      roll_case("R6 April 29 to 30", edge_t(8'h23, 8'h11, 8'h29, 8'h04, 8'h22),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h30, 8'h04, 8'h22));
      roll_case("R6 Feb 28 common year", edge_t(8'h23, 8'h11, 8'h28, 8'h02, 8'h23),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h03, 8'h23));
      roll_case("R6 Feb 28 leap year", edge_t(8'h23, 8'h11, 8'h28, 8'h02, 8'h24),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h29, 8'h02, 8'h24));
      roll_case("R6 Feb 29 leap year 00", edge_t(8'h23, 8'h11, 8'h29, 8'h02, 8'h00),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h03, 8'h00));
      roll_case("R6 Jan 31 to Feb 1", edge_t(8'h23, 8'h11, 8'h31, 8'h01, 8'h22),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h02, 8'h22));
      roll_case("R6 Sep 30 to Oct 1", edge_t(8'h23, 8'h11, 8'h30, 8'h09, 8'h22),
                pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h10, 8'h22));
   endtask

   task automatic t_osc_stop();
      logic [63:0] v;
      v = pack(8'h10, 8'h20, 8'h30, 8'h05, 8'h31, 8'h02, 8'h03, 8'h04);
      do_load(v);
      do_ticks(10);
      do_snap();
      check("R7 oscillator stop holds count", snap_a, v);
   endtask

   task automatic t_abort();
      logic [63:0] v;
      v = pack(8'h00, 8'h00, 8'h00, 8'h12, 8'h02, 8'h09, 8'h09, 8'h09);
      do_load(v);
      @(negedge clk) ext_rst_n_i = 1'b0;
      @(negedge clk) check("R8 abort when enabled", {63'd0, abort_a}, 64'd1);
      do_snap();
      check("R8 abort leaves registers", snap_a, v);
      ext_rst_n_i = 1'b1;
      #1 check("R8 no abort with reset high", {63'd0, abort_a}, 64'd0);
   endtask

   task automatic t_load_prio();
      logic [63:0] v;
      v = pack(8'h50, 8'h10, 8'h10, 8'h10, 8'h13, 8'h10, 8'h10, 8'h10);
      @(negedge clk) begin load_i = 1'b1; tick_i = 1'b1; load_data_i = v; end
      @(negedge clk) begin load_i = 1'b0; tick_i = 1'b0; end
      do_snap();
      check("R10 load beats tick", snap_a, v);
   endtask

   task automatic t_snap_hold();
      logic [63:0] v;
      v = pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00);
      do_load(v);
      do_snap();
      do_ticks(3);
      check("R11 snapshot held while counting", snap_a, v);
      do_snap();
      check("R11 new snapshot", snap_a, pack(8'h03, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
   endtask

   task automatic t_prescale();
      do_load(pack(8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00));
      @(negedge clk) tick_d = 1'b1;
      repeat (6) @(negedge clk);
      @(negedge clk) tick_d = 1'b0;
      do_snap();
      check("R12 seven ticks one step", {56'd0, snap_b[7:0]}, 64'h01);
      @(negedge clk) tick_d = 1'b1;
      @(negedge clk) tick_d = 1'b0;
      do_snap();
      check("R12 eighth tick second step", {56'd0, snap_b[7:0]}, 64'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_count();
      t_24h();
      t_12h();
      t_months();
      t_osc_stop();
      t_abort();
      t_load_prio();
      t_snap_hold();
      t_prescale();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule